// File: doc/BRIEF.md
# CAN Last-Error Classifier

This block watches the bit stream of a CAN node and records the most recent error it sees as a 3-bit code. A CPU reads that code and clears a pending interrupt by reading. The block compares the level the node drives with the level it samples, and it counts runs of equal bits where stuffing applies. Form, acknowledge and checksum errors come in as one-cycle pulses from the protocol engine that parses frames. Frame parsing, checksum calculation and error counting are done outside this block.

When a frame finishes cleanly, the code drops back to zero. Software may store code 7 in the field. The hardware never produces 7, so software can tell when a later hardware update has happened. During bus-off recovery, the bit0 code is written again each time the bus shows a full run of recessive bits. Software can use this to follow the recovery. Every input is sampled on the rising clock edge. The code and the interrupt flag are registered outputs. Reset is synchronous and active high.

Top module: `can_lec_unit`

## Requirements
- R1: While reset is applied and in the first cycle after it, `lec_code` reads 0 and `irq_pend` reads 0.
- R2: The codes are 1 for a stuff error, 2 for a form error, 3 for an ack error, 4 for a bit1 error, 5 for a bit0 error and 6 for a checksum error. A pulse on `form_err_p`, `ack_err_p` or `crc_err_p` records 2, 3 or 6 in the next cycle.
- R3: A `frame_ok_p` pulse with no error in the same cycle sets `lec_code` to 0 in the next cycle.
- R4: A CPU write (`cpu_wr`) stores `cpu_wdata`, including 7, and the value holds until the hardware updates it. The hardware never writes 7.
- R5: On a strobed bit with `in_stuff_zone` high, if this bit makes more than STUFF_LIMIT (default 5) equal bits in a row, code 1 is recorded. A run of exactly five does not record it. A long run outside the zone records nothing.
- R6: A strobed bit with `tx_bit`=1, `rx_bit`=0 and `in_tx_msg` high records code 4. While `in_arb` is high this check is suppressed.
- R7: A strobed bit with `tx_bit`=0 and `rx_bit`=1 records code 5 when any of `in_tx_msg`, `in_ack_slot`, `in_err_flag` or `in_ovl_flag` is high. Otherwise it records nothing.
- R8: While `in_busoff_rec` is high, every REC_LEN (default 11) strobed recessive bits in a row record code 5. A dominant bit restarts the count, and so does each detection.
- R9: When several errors occur in one cycle, the code recorded follows this priority: bit0, bit1, stuff, form, ack, checksum.
- R10: An error update takes precedence over `frame_ok_p`, and both take precedence over a CPU write in the same cycle.
- R11: Every recorded error sets `irq_pend`. The flag stays set until a `cpu_rd` cycle that has no new error clears it.
- R12: The bit checks and the run counters act only on cycles where `bit_stb` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | Bit sample strobe |
| tx_bit | input | 1 | Level driven by the node (1 = recessive) |
| rx_bit | input | 1 | Level sampled from the bus |
| in_arb | input | 1 | Arbitration field in progress |
| in_tx_msg | input | 1 | Node is transmitting a message |
| in_stuff_zone | input | 1 | Bit stuffing applies to this bit |
| in_ack_slot | input | 1 | Node drives the ack slot |
| in_err_flag | input | 1 | Active error flag being sent |
| in_ovl_flag | input | 1 | Overload flag being sent |
| in_busoff_rec | input | 1 | Bus-off recovery in progress |
| form_err_p | input | 1 | Form error pulse |
| ack_err_p | input | 1 | Ack error pulse |
| crc_err_p | input | 1 | Checksum error pulse |
| frame_ok_p | input | 1 | Frame completed without error |
| cpu_wr | input | 1 | CPU write strobe for the code field |
| cpu_rd | input | 1 | CPU read strobe of the status register |
| cpu_wdata | input | 3 | Code value written by the CPU |
| lec_code | output | 3 | Last error code |
| irq_pend | output | 1 | Interrupt pending |

## Verification
The assertions check the per-cycle rules on every cycle. Any detected error sets the interrupt and a read clears it. The flag stays put when neither happens. A clean frame zeroes the code, and hardware never leaves 7 behind. Bit-level hits lead to codes 4 and 5, and no hit fires without a strobe. Only the bench's scenarios can show behaviour that depends on history. That covers the sixth equal bit against the fifth, an eleven-bit recessive run restarted by a dominant bit, a probe value of 7 that survives idle cycles, and counter state left untouched across cycles without a strobe.

// File: rtl/can_lec_pkg.sv
package can_lec_pkg;

  typedef enum logic [2:0] {
    LEC_NONE  = 3'd0,
    LEC_STUFF = 3'd1,
    LEC_FORM  = 3'd2,
    LEC_ACK   = 3'd3,
    LEC_BIT1  = 3'd4,
    LEC_BIT0  = 3'd5,
    LEC_CRC   = 3'd6,
    LEC_PROBE = 3'd7
  } lec_e;

  // Next length of a run of equal bits, saturating at cap.
  function automatic int run_step(int cnt, logic same, int cap);
    if (cnt == 0 || !same) return 1;
    return (cnt >= cap) ? cap : cnt + 1;
  endfunction

  // Fixed priority among simultaneous error sources.
  function automatic lec_e pick_code(logic b0, logic b1, logic st,
                                     logic fm, logic ak, logic cr);
    if (b0) return LEC_BIT0;
    if (b1) return LEC_BIT1;
    if (st) return LEC_STUFF;
    if (fm) return LEC_FORM;
    if (ak) return LEC_ACK;
    if (cr) return LEC_CRC;
    return LEC_NONE;
  endfunction

endpackage

// File: rtl/lec_run_mon.sv
module lec_run_mon
  import can_lec_pkg::*;
#(
  parameter int STUFF_LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic rx,
  input  logic zone,
  output logic hit
);
  localparam int CAP   = STUFF_LIMIT + 1;
  localparam int RUN_W = $clog2(CAP + 1);

  logic [RUN_W-1:0] cnt_q;
  logic             last_q;
  int               nxt_i;

  always_comb begin
    nxt_i = run_step(int'(cnt_q), rx == last_q, CAP);
    hit   = stb && zone && (nxt_i > STUFF_LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      last_q <= 1'b1;
    end else if (stb) begin
      cnt_q  <= RUN_W'(nxt_i);
      last_q <= rx;
    end
  end
endmodule

// File: rtl/lec_rec_mon.sv
module lec_rec_mon #(
  parameter int REC_LEN = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic rx,
  input  logic active,
  output logic hit
);
  localparam int CW = $clog2(REC_LEN);

  logic [CW-1:0] cnt_q;

  assign hit = stb && active && rx && (cnt_q == CW'(REC_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q <= '0;
    end else if (stb) begin
      if (!rx || hit) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lec_bit_cmp.sv
module lec_bit_cmp (
  input  logic stb,
  input  logic tx,
  input  logic rx,
  input  logic arb,
  input  logic tx_msg,
  input  logic ack_slot,
  input  logic err_flag,
  input  logic ovl_flag,
  output logic bit1_hit,
  output logic bit0_hit
);
  logic drive0_zone;

  always_comb begin
    drive0_zone = tx_msg || ack_slot || err_flag || ovl_flag;
    bit1_hit    = stb && tx && !rx && tx_msg && !arb;
    bit0_hit    = stb && !tx && rx && drive0_zone;
  end
endmodule

// File: rtl/can_lec_unit.sv
module can_lec_unit
  import can_lec_pkg::*;
#(
  parameter int STUFF_LIMIT = 5,
  parameter int REC_LEN     = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_stb,
  input  logic       tx_bit,
  input  logic       rx_bit,
  input  logic       in_arb,
  input  logic       in_tx_msg,
  input  logic       in_stuff_zone,
  input  logic       in_ack_slot,
  input  logic       in_err_flag,
  input  logic       in_ovl_flag,
  input  logic       in_busoff_rec,
  input  logic       form_err_p,
  input  logic       ack_err_p,
  input  logic       crc_err_p,
  input  logic       frame_ok_p,
  input  logic       cpu_wr,
  input  logic       cpu_rd,
  input  logic [2:0] cpu_wdata,
  output logic [2:0] lec_code,
  output logic       irq_pend
);
  logic stuff_hit, bit1_hit, bit0_hit, rec_hit, err_any;
  lec_e hw_code;
  logic [2:0] lec_q;
  logic       irq_q;

  lec_run_mon #(.STUFF_LIMIT(STUFF_LIMIT)) u_run (
    .clk(clk), .rst(rst), .stb(bit_stb), .rx(rx_bit),
    .zone(in_stuff_zone), .hit(stuff_hit)
  );

  lec_rec_mon #(.REC_LEN(REC_LEN)) u_rec (
    .clk(clk), .rst(rst), .stb(bit_stb), .rx(rx_bit),
    .active(in_busoff_rec), .hit(rec_hit)
  );

  lec_bit_cmp u_cmp (
    .stb(bit_stb), .tx(tx_bit), .rx(rx_bit), .arb(in_arb),
    .tx_msg(in_tx_msg), .ack_slot(in_ack_slot), .err_flag(in_err_flag),
    .ovl_flag(in_ovl_flag), .bit1_hit(bit1_hit), .bit0_hit(bit0_hit)
  );

  always_comb begin
    err_any = stuff_hit || bit1_hit || bit0_hit || rec_hit ||
              form_err_p || ack_err_p || crc_err_p;
    hw_code = pick_code(bit0_hit || rec_hit, bit1_hit, stuff_hit,
                        form_err_p, ack_err_p, crc_err_p);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lec_q <= 3'd0;
      irq_q <= 1'b0;
    end else begin
      if (err_any)         lec_q <= hw_code;
      else if (frame_ok_p) lec_q <= 3'd0;
      else if (cpu_wr)     lec_q <= cpu_wdata;

      if (err_any)     irq_q <= 1'b1;
      else if (cpu_rd) irq_q <= 1'b0;
    end
  end

  assign lec_code = lec_q;
  assign irq_pend = irq_q;
endmodule

// File: rtl/lec_chk.sv
module lec_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_stb,
  input logic       cpu_rd,
  input logic       frame_ok_p,
  input logic [2:0] lec_code,
  input logic       irq_pend,
  input logic       err_any,
  input logic       stuff_hit,
  input logic       bit1_hit,
  input logic       bit0_hit,
  input logic       rec_hit
);
  AST_ERR_SETS_IRQ: assert property (@(posedge clk) disable iff (rst)
    err_any |=> irq_pend); // R11
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cpu_rd && !err_any |=> !irq_pend); // R11
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !err_any && !cpu_rd |=> $stable(irq_pend)); // R11
  AST_CLEAN_FRAME_ZERO: assert property (@(posedge clk) disable iff (rst)
    frame_ok_p && !err_any |=> lec_code == 3'd0); // R3
  AST_HW_NEVER_SEVEN: assert property (@(posedge clk) disable iff (rst)
    err_any || frame_ok_p |=> lec_code != 3'd7); // R4
  AST_BIT0_CODE: assert property (@(posedge clk) disable iff (rst)
    bit0_hit || rec_hit |=> lec_code == 3'd5); // R7
  AST_BIT1_CODE: assert property (@(posedge clk) disable iff (rst)
    bit1_hit && !bit0_hit && !rec_hit |=> lec_code == 3'd4); // R6
  AST_STROBE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |-> !(stuff_hit || bit1_hit || bit0_hit || rec_hit)); // R12
endmodule

bind can_lec_unit lec_chk u_lec_chk (
  .clk(clk), .rst(rst), .bit_stb(bit_stb), .cpu_rd(cpu_rd),
  .frame_ok_p(frame_ok_p), .lec_code(lec_code), .irq_pend(irq_pend),
  .err_any(err_any), .stuff_hit(stuff_hit), .bit1_hit(bit1_hit),
  .bit0_hit(bit0_hit), .rec_hit(rec_hit)
);

// File: tb/tb_can_lec_unit.sv
`timescale 1ns/1ps
module tb_can_lec_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_stb = 0, tx_bit = 1, rx_bit = 1;
  logic in_arb = 0, in_tx_msg = 0, in_stuff_zone = 0, in_ack_slot = 0;
  logic in_err_flag = 0, in_ovl_flag = 0, in_busoff_rec = 0;
  logic form_err_p = 0, ack_err_p = 0, crc_err_p = 0, frame_ok_p = 0;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [2:0] cpu_wdata = 3'd0;
  logic [2:0] lec_code;
  logic irq_pend;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";
  bit cmp_on = 0;

  always #2 clk = ~clk;

  can_lec_unit dut (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .tx_bit(tx_bit), .rx_bit(rx_bit),
    .in_arb(in_arb), .in_tx_msg(in_tx_msg), .in_stuff_zone(in_stuff_zone),
    .in_ack_slot(in_ack_slot), .in_err_flag(in_err_flag),
    .in_ovl_flag(in_ovl_flag), .in_busoff_rec(in_busoff_rec),
    .form_err_p(form_err_p), .ack_err_p(ack_err_p), .crc_err_p(crc_err_p),
    .frame_ok_p(frame_ok_p), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .lec_code(lec_code), .irq_pend(irq_pend)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Behavioural reference model
  bit hist[$];
  bit recq[$];
  int m_lec = 0, m_irq = 0;

  always @(posedge clk) begin
    int run, code;
    bit st, det, b1, b0, err;
    if (rst) begin
      hist.delete(); recq.delete(); m_lec = 0; m_irq = 0;
    end else begin
      st = 0; det = 0; run = 0;
      if (bit_stb) begin
        hist.push_back(rx_bit);
        if (hist.size() > 16) void'(hist.pop_front());
        for (int i = hist.size() - 1; i >= 0; i--) begin
          if (hist[i] != rx_bit) break;
          run++;
        end
        st = in_stuff_zone && run > 5;
      end
      if (!in_busoff_rec) recq.delete();
      else if (bit_stb) begin
        if (!rx_bit) recq.delete();
        else begin
          recq.push_back(1'b1);
          if (recq.size() == 11) begin det = 1; recq.delete(); end
        end
      end
      b1 = bit_stb && tx_bit && !rx_bit && in_tx_msg && !in_arb;
      b0 = bit_stb && !tx_bit && rx_bit &&
           (in_tx_msg || in_ack_slot || in_err_flag || in_ovl_flag);
      err = 1; code = 0;
      if (b0 || det) code = 5;
      else if (b1) code = 4;
      else if (st) code = 1;
      else if (form_err_p) code = 2;
      else if (ack_err_p) code = 3;
      else if (crc_err_p) code = 6;
      else err = 0;
      if (err) begin m_lec = code; m_irq = 1; end
      else if (frame_ok_p) m_lec = 0;
      else if (cpu_wr) m_lec = cpu_wdata;
      if (!err && cpu_rd) m_irq = 0;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      check(cur_req, lec_code, m_lec);
      check(cur_req, irq_pend, m_irq);
    end
    if (cyc > 5000) begin
      n_fail++; n_chk++;
      $display("FAIL R12: watchdog expired, got 0 expected 1");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic strobe(bit tx, bit rx);
    bit_stb = 1; tx_bit = tx; rx_bit = rx; tick(); bit_stb = 0;
  endtask

  task automatic clean();
    frame_ok_p = 1; cpu_rd = 1; tick(); frame_ok_p = 0; cpu_rd = 0;
  endtask

  initial begin
    @(negedge clk); cmp_on = 1;
    tick(3);
    check("R1", lec_code, 0); check("R1", irq_pend, 0);
    rst = 0; tick();
    check("R1", lec_code, 0); check("R1", irq_pend, 0);

    cur_req = "R2";
    form_err_p = 1; tick(); form_err_p = 0;
    check("R2", lec_code, 2); check("R11", irq_pend, 1);
    tick(3); check("R11", irq_pend, 1);
    cpu_rd = 1; tick(); cpu_rd = 0; check("R11", irq_pend, 0);
    cur_req = "R3";
    frame_ok_p = 1; tick(); frame_ok_p = 0; check("R3", lec_code, 0);
    cur_req = "R2";
    ack_err_p = 1; tick(); ack_err_p = 0; check("R2", lec_code, 3);
    crc_err_p = 1; tick(); crc_err_p = 0; check("R2", lec_code, 6);

    cur_req = "R4";
    cpu_wr = 1; cpu_wdata = 3'd7; tick(); cpu_wr = 0;
    check("R4", lec_code, 7);
    tick(4); check("R4", lec_code, 7);
    frame_ok_p = 1; tick(); frame_ok_p = 0; check("R4", lec_code, 0);

    cur_req = "R10";
    cpu_wr = 1; form_err_p = 1; tick(); cpu_wr = 0; form_err_p = 0;
    check("R10", lec_code, 2);
    cpu_wr = 1; frame_ok_p = 1; tick(); cpu_wr = 0; frame_ok_p = 0;
    check("R10", lec_code, 0);
    clean();

    cur_req = "R5";
    in_stuff_zone = 1;
    strobe(1, 1);
    for (int i = 0; i < 5; i++) strobe(1, 0);
    check("R5", lec_code, 0);
    strobe(1, 0); check("R5", lec_code, 1);
    clean();
    in_stuff_zone = 0;
    for (int i = 0; i < 8; i++) strobe(1, 1);
    check("R5", lec_code, 0);
    in_stuff_zone = 1;
    for (int i = 0; i < 10; i++) strobe(1, 1'(i % 2));
    check("R5", lec_code, 0);

    cur_req = "R12";
    strobe(1, 1);
    for (int i = 0; i < 5; i++) strobe(1, 0);
    in_tx_msg = 1; tx_bit = 0; rx_bit = 1; tick(3);
    check("R12", lec_code, 0);
    in_tx_msg = 0;
    strobe(1, 0); check("R12", lec_code, 1);
    in_stuff_zone = 0;
    clean();

    cur_req = "R6";
    in_tx_msg = 1; in_arb = 1;
    strobe(1, 0); check("R6", lec_code, 0);
    in_arb = 0;
    strobe(1, 0); check("R6", lec_code, 4);
    in_tx_msg = 0; clean();

    cur_req = "R7";
    strobe(0, 1); check("R7", lec_code, 0);
    in_ack_slot = 1; strobe(0, 1); in_ack_slot = 0;
    check("R7", lec_code, 5);
    clean();
    in_err_flag = 1; strobe(0, 1); in_err_flag = 0;
    check("R7", lec_code, 5);
    clean();
    in_ovl_flag = 1; strobe(0, 1); in_ovl_flag = 0;
    check("R7", lec_code, 5);
    clean();

    cur_req = "R8";
    in_busoff_rec = 1;
    for (int i = 0; i < 10; i++) strobe(1, 1);
    check("R8", lec_code, 0);
    strobe(1, 0);
    for (int i = 0; i < 10; i++) strobe(1, 1);
    check("R8", lec_code, 0);
    strobe(1, 1); check("R8", lec_code, 5);
    cpu_wr = 1; cpu_wdata = 3'd0; cpu_rd = 1; tick(); cpu_wr = 0; cpu_rd = 0;
    for (int i = 0; i < 10; i++) strobe(1, 1);
    check("R8", lec_code, 0);
    strobe(1, 1); check("R8", lec_code, 5);
    in_busoff_rec = 0; clean();

    cur_req = "R9";
    in_stuff_zone = 1; in_tx_msg = 1;
    strobe(1, 1);
    for (int i = 0; i < 5; i++) strobe(1, 0);
    form_err_p = 1; crc_err_p = 1;
    strobe(1, 0); form_err_p = 0; crc_err_p = 0;
    check("R9", lec_code, 4);
    in_stuff_zone = 0; in_tx_msg = 0;
    form_err_p = 1; crc_err_p = 1; tick(); form_err_p = 0; crc_err_p = 0;
    check("R9", lec_code, 2);
    ack_err_p = 1; crc_err_p = 1; tick(); ack_err_p = 0; crc_err_p = 0;
    check("R9", lec_code, 3);

    cur_req = "R11";
    cpu_rd = 1; crc_err_p = 1; tick(); cpu_rd = 0; crc_err_p = 0;
    check("R11", irq_pend, 1);
    cpu_rd = 1; tick(); cpu_rd = 0; check("R11", irq_pend, 0);
    tick(2);

    cmp_on = 0;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule